// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block keeps one reservation per processor core so that software can build atomic read-modify-write sequences from a load-linked (LL) and a store-conditional (SC) operation. It watches each core's data-side requests, which are a plain load, a plain store, an LL or an SC. It also watches the invalidation snoops that the coherence side sends to that core's data cache. From these it decides, in the same cycle as an SC, whether the SC succeeds.

The success decision does two things. It gates the memory write enable, so a failed SC never reaches memory. It also forms the value that the memory stage writes back to the SC's destination register: 1 on success and 0 on failure. An LL records the word address it loads from. The reservation is lost when a snoop invalidates the block holding that word, when the same core does a plain store to that word, or after any SC. Each core's reservation is independent of the others.

Top module: `llsc_link_unit`

## Requirements
- R1: The request opcode on `req_op` is 0 for a load, 1 for a store, 2 for LL and 3 for SC. An LL records the word address (`req_addr` bits ADDR_W-1:2) as that core's valid link, so a later SC to the same word succeeds.
- R2: `sc_success` is high only in a cycle with a valid SC whose word address equals the valid linked word address and whose link is not being snooped away in that cycle. Byte offset bits 1:0 are ignored in the compare.
- R3: `mem_write_en` is high for a valid store and for a successful SC. It is low for a failed SC, for a load, for an LL and when `req_valid` is low.
- R4: `sc_rd_value` equals 1 during a successful SC and 0 during a failed SC. It is 0 in every cycle without an SC.
- R5: A snoop invalidation to the core's block holding the linked word clears the link. Block address is bits ADDR_W-1:3. A snoop to that block in the same cycle as an SC makes the SC fail. A snoop to the LL's own block in the same cycle as the LL leaves the link invalid.
- R6: Every SC clears the link after its cycle, whether it succeeds or fails.
- R7: A plain store from the same core to the linked word clears the link. A plain store to a different word does not, even when that word is in the same block.
- R8: After reset no core holds a link, so an SC with no prior LL fails.
- R9: Requests and snoops of one core never change another core's link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Per-core request valid |
| req_op | input | 2*NUM_CORES | Per-core opcode (0 load, 1 store, 2 LL, 3 SC) |
| req_addr | input | ADDR_W*NUM_CORES | Per-core byte address |
| snoop_valid | input | NUM_CORES | Per-core snoop invalidation valid |
| snoop_addr | input | ADDR_W*NUM_CORES | Per-core snoop invalidation address |
| mem_write_en | output | NUM_CORES | Per-core gated memory write enable |
| sc_success | output | NUM_CORES | Per-core SC success flag |
| sc_rd_value | output | DATA_W*NUM_CORES | Per-core value for the SC destination register |

## Verification
The bench builds the unit with three cores and a 12-bit address, with the default 4-byte word and 2-word block. The random address pool spans only four blocks, so links, matching SCs, same-block stores to the other word and snoop hits all occur often. The third core shows whether lane indexing of the flattened ports goes beyond the simple two-lane case. Directed sequences cover same-cycle snoop against SC and against LL, a repeated SC, and cross-core isolation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;

endpackage

// File: rtl/llsc_link_slot.sv
module llsc_link_slot
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_LSB  = 2,
  parameter int BLOCK_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  llsc_op_e          req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              sc_ok
);

  localparam int WORD_W  = ADDR_W - WORD_LSB;
  localparam int BLOCK_W = ADDR_W - BLOCK_LSB;
  localparam int SUB_W   = BLOCK_LSB - WORD_LSB;

  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WORD_LSB];
  endfunction

  function automatic logic [BLOCK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLOCK_LSB];
  endfunction

  function automatic logic [BLOCK_W-1:0] block_of_word(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:SUB_W];
  endfunction

  logic              link_vld;
  logic [WORD_W-1:0] link_word;

  // named events for the assertions
  logic is_ll, is_sc, is_store;
  logic word_hit, snoop_kills_link, snoop_kills_ll;
  logic ev_set, ev_clr_snoop, ev_clr_sc, ev_clr_store;

  always_comb begin
    is_ll            = req_valid && (req_op == OP_LL);
    is_sc            = req_valid && (req_op == OP_SC);
    is_store         = req_valid && (req_op == OP_STORE);
    word_hit         = link_vld && (word_of(req_addr) == link_word);
    snoop_kills_link = link_vld && snoop_valid &&
                       (block_of(snoop_addr) == block_of_word(link_word));
    snoop_kills_ll   = snoop_valid && (block_of(snoop_addr) == block_of(req_addr));
    ev_set           = is_ll && !snoop_kills_ll;
    ev_clr_snoop     = snoop_kills_link;
    ev_clr_sc        = is_sc;
    ev_clr_store     = is_store && word_hit;
    sc_ok            = is_sc && word_hit && !snoop_kills_link;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_vld  <= 1'b0;
      link_word <= '0;
    end else if (is_ll) begin
      link_vld  <= ev_set;
      link_word <= word_of(req_addr);
    end else if (ev_clr_snoop || ev_clr_sc || ev_clr_store) begin
      link_vld  <= 1'b0;
    end
  end

  assert_ll_records_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set |=> (link_vld && link_word == $past(word_of(req_addr))));

  assert_snoop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_kills_link && !is_ll) |=> !link_vld);

  assert_snoop_beats_ll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ll && snoop_kills_ll) |=> !link_vld);

  assert_sc_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> !link_vld);

  assert_store_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr_store |=> !link_vld);

  assert_reset_empty_R8: assert property (@(posedge clk)
    !rst_n |=> !link_vld);

endmodule

// File: rtl/llsc_commit_gate.sv
module llsc_commit_gate
  import llsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              req_valid,
  input  llsc_op_e          req_op,
  input  logic              sc_ok,
  output logic              mem_we,
  output logic              success,
  output logic [DATA_W-1:0] rd_value
);

  function automatic logic [DATA_W-1:0] status_word(input logic ok);
    return {{(DATA_W-1){1'b0}}, ok};
  endfunction

  logic plain_store, cond_store;

  always_comb begin
    plain_store = req_valid && (req_op == OP_STORE);
    cond_store  = req_valid && (req_op == OP_SC);
    success     = cond_store && sc_ok;
    mem_we      = plain_store || success;
    rd_value    = cond_store ? status_word(success) : '0;
  end

  always_comb begin
    assert_load_no_write_R3: assert (!(req_valid && (req_op == OP_LOAD || req_op == OP_LL) && mem_we));
  end

endmodule

// File: rtl/llsc_link_unit.sv
module llsc_link_unit
  import llsc_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_WORDS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        req_valid,
  input  logic [2*NUM_CORES-1:0]      req_op,
  input  logic [ADDR_W*NUM_CORES-1:0] req_addr,
  input  logic [NUM_CORES-1:0]        snoop_valid,
  input  logic [ADDR_W*NUM_CORES-1:0] snoop_addr,
  output logic [NUM_CORES-1:0]        mem_write_en,
  output logic [NUM_CORES-1:0]        sc_success,
  output logic [DATA_W*NUM_CORES-1:0] sc_rd_value
);

  localparam int WORD_LSB  = $clog2(WORD_BYTES);
  localparam int BLOCK_LSB = WORD_LSB + $clog2(BLOCK_WORDS);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    llsc_op_e          op;
    logic              sc_ok;
    logic [DATA_W-1:0] rd_val;

    assign op = llsc_op_e'(req_op[2*c +: 2]);

    llsc_link_slot #(
      .ADDR_W   (ADDR_W),
      .WORD_LSB (WORD_LSB),
      .BLOCK_LSB(BLOCK_LSB)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid[c]),
      .req_op     (op),
      .req_addr   (req_addr[ADDR_W*c +: ADDR_W]),
      .snoop_valid(snoop_valid[c]),
      .snoop_addr (snoop_addr[ADDR_W*c +: ADDR_W]),
      .sc_ok      (sc_ok)
    );

    llsc_commit_gate #(
      .DATA_W(DATA_W)
    ) u_gate (
      .req_valid(req_valid[c]),
      .req_op   (op),
      .sc_ok    (sc_ok),
      .mem_we   (mem_write_en[c]),
      .success  (sc_success[c]),
      .rd_value (rd_val)
    );

    assign sc_rd_value[DATA_W*c +: DATA_W] = rd_val;

    assert_sc_write_needs_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[c] && op == OP_SC && mem_write_en[c]) |-> sc_ok);

    assert_rd_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_rd_value[DATA_W*c +: DATA_W] != '0) |-> (sc_success[c] && sc_ok));

    assert_success_only_on_sc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sc_ok |-> (req_valid[c] && op == OP_SC));
  end

endmodule

// File: tb/llsc_link_unit_test.sv
module llsc_link_unit_test;

  localparam int NC = 3;
  localparam int AW = 12;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NC-1:0]    req_valid;
  logic [2*NC-1:0]  req_op;
  logic [AW*NC-1:0] req_addr;
  logic [NC-1:0]    snoop_valid;
  logic [AW*NC-1:0] snoop_addr;
  logic [NC-1:0]    mem_write_en;
  logic [NC-1:0]    sc_success;
  logic [DW*NC-1:0] sc_rd_value;

  always #10 clk = ~clk;

  llsc_link_unit #(
    .NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW), .WORD_BYTES(4), .BLOCK_WORDS(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_write_en(mem_write_en), .sc_success(sc_success), .sc_rd_value(sc_rd_value)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // stimulus per core
  logic          v  [NC];
  logic [1:0]    op [NC];
  logic [AW-1:0] ad [NC];
  logic          sv [NC];
  logic [AW-1:0] sa [NC];

  // reference model
  logic          m_vld [NC];
  logic [AW-1:0] m_adr [NC];

  function automatic logic same_word(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a >> 2) == (b >> 2);
  endfunction

  function automatic logic same_block(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a / 8) == (b / 8);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_all();
    for (int c = 0; c < NC; c++) begin
      v[c] = 0; op[c] = 0; ad[c] = '0; sv[c] = 0; sa[c] = '0;
    end
  endtask

  // drive, check combinational results, advance the model
  task automatic step(input string tag);
    logic ok, snoop_hit, is_sc, is_st;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      req_valid[c] = v[c];
      req_op[2*c +: 2] = op[c];
      req_addr[AW*c +: AW] = ad[c];
      snoop_valid[c] = sv[c];
      snoop_addr[AW*c +: AW] = sa[c];
    end
    #2;
    for (int c = 0; c < NC; c++) begin
      is_sc = v[c] && op[c] == 2'd3;
      is_st = v[c] && op[c] == 2'd1;
      snoop_hit = m_vld[c] && sv[c] && same_block(sa[c], m_adr[c]);
      ok = is_sc && m_vld[c] && same_word(ad[c], m_adr[c]) && !snoop_hit;
      check({tag, " R2 sc_success"}, DW'(sc_success[c]), DW'(ok));
      check({tag, " R3 mem_write_en"}, DW'(mem_write_en[c]), DW'(is_st || ok));
      check({tag, " R4 sc_rd_value"}, sc_rd_value[DW*c +: DW], is_sc ? DW'(ok) : '0);
      if (v[c] && op[c] == 2'd2) begin
        m_vld[c] = !(sv[c] && same_block(sa[c], ad[c]));
        m_adr[c] = ad[c];
      end else if (snoop_hit || is_sc || (is_st && m_vld[c] && same_word(ad[c], m_adr[c]))) begin
        m_vld[c] = 0;
      end
    end
  endtask

  task automatic one(input int c, input logic [1:0] o, input logic [AW-1:0] a, input string tag);
    idle_all();
    v[c] = 1; op[c] = o; ad[c] = a;
    step(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NC; c++) begin m_vld[c] = 0; m_adr[c] = '0; end
    idle_all();
    req_valid = '0; req_op = '0; req_addr = '0; snoop_valid = '0; snoop_addr = '0;
    repeat (3) @(negedge clk);
    check("R8 reset write_en", DW'(mem_write_en), '0);
    rst_n = 1'b1;

    // R8: SC with no prior LL fails
    one(0, 2'd3, 12'h100, "R8 sc without ll");
    // R1: LL then SC same word (different byte offset) succeeds
    one(1, 2'd2, 12'h204, "R1 ll");
    one(1, 2'd3, 12'h206, "R1 sc after ll");
    // R6: second SC fails
    one(1, 2'd2, 12'h204, "R6 ll");
    one(1, 2'd3, 12'h204, "R6 first sc");
    one(1, 2'd3, 12'h204, "R6 repeat sc");
    // R5: snoop to other word of the linked block clears
    one(0, 2'd2, 12'h300, "R5 ll");
    idle_all(); sv[0] = 1; sa[0] = 12'h304; step("R5 snoop");
    one(0, 2'd3, 12'h300, "R5 sc after snoop");
    // R5: same-cycle snoop and SC
    one(0, 2'd2, 12'h300, "R5 ll2");
    idle_all(); v[0] = 1; op[0] = 2'd3; ad[0] = 12'h300; sv[0] = 1; sa[0] = 12'h300;
    step("R5 snoop with sc");
    // R5: same-cycle snoop and LL
    idle_all(); v[0] = 1; op[0] = 2'd2; ad[0] = 12'h310; sv[0] = 1; sa[0] = 12'h314;
    step("R5 snoop with ll");
    one(0, 2'd3, 12'h310, "R5 sc after snooped ll");
    // R7: store to other word of same block keeps link, store to word clears
    one(2, 2'd2, 12'h400, "R7 ll");
    one(2, 2'd1, 12'h404, "R7 store other word");
    one(2, 2'd3, 12'h400, "R7 sc survives");
    one(2, 2'd2, 12'h400, "R7 ll2");
    one(2, 2'd1, 12'h402, "R7 store linked word");
    one(2, 2'd3, 12'h400, "R7 sc after store");
    // R9: other core activity leaves link intact
    one(0, 2'd2, 12'h500, "R9 ll core0");
    idle_all(); v[1] = 1; op[1] = 2'd3; ad[1] = 12'h500; sv[2] = 1; sa[2] = 12'h500;
    v[2] = 1; op[2] = 2'd1; ad[2] = 12'h500; step("R9 other cores");
    one(0, 2'd3, 12'h500, "R9 sc core0");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < NC; c++) begin
        v[c]  = ($urandom % 4) != 0;
        op[c] = 2'($urandom % 4);
        ad[c] = 12'h600 + 12'(($urandom % 8) * 4) + 12'($urandom % 4);
        sv[c] = ($urandom % 5) == 0;
        sa[c] = 12'h600 + 12'(($urandom % 8) * 4);
      end
      step("random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule